// File: doc/BRIEF.md
# Dual-Segment RAM Write Guard

This block sits in front of a RAM and decides, for every write access, whether the write may proceed. Software sets up two protection segments. Each segment has a start word address, an end word address and a two-bit enable field. One enable bit covers user-data writes and the other covers supervisor-data writes. Each access arrives with a byte address, a double-word flag and a four-bit address-space code. The block gates the RAM write enable and gives a fault pulse in the same cycle as the access strobe.

A mode input chooses how the segments are read. In block mode, a write that falls in an enabled segment is refused. In permit mode, a write is refused unless it falls in an enabled segment. When both enable fields are zero, checking is off and every write goes through. Register writes that set reserved bits raise a sticky register-parity error flag, and the legal fields are still stored. A sticky fault flag records that at least one write has been refused since reset.

Top module: `ram_write_guard`

## Requirements
- R1: After reset every start address, end address and enable field is zero. Reads of the four segment registers return 0. The fault flag and the parity error flag are 0.
- R2: A write to offset 0x20+8*i stores bits 22:0 as the start word address of segment i and bits 24:23 as its enable field. A write to offset 0x24+8*i stores bits 22:0 as the end word address. A start register reads back as {7'b0, enable, start}. An end register reads back as {9'b0, end}. Any other offset reads 0.
- R3: A start-register write with any of bits 31:25 set, or an end-register write with any of bits 31:23 set, sets the sticky parity error flag from the next cycle on. The legal fields of that write are still stored.
- R4: A segment can be hit only by a user-data access (space code 0xA) when its enable bit 0 is set, or by a supervisor-data access (space code 0xB) when its enable bit 1 is set. Other space codes never hit.
- R5: The word address is byte address bits 22:2. A segment is hit when start <= word and (word | double-word flag) < end. The end address is exclusive.
- R6: In block mode (blockMode=1), with checking on, a write is refused when any segment is hit.
- R7: In permit mode (blockMode=0), with checking on, a write is refused unless a segment with a nonzero enable field is hit.
- R8: When both enable fields are zero, every write is allowed in either mode.
- R9: ramWe and faultPulse are combinational on the access strobe. Exactly one of them is high while accValid is high. Both are low while accValid is low.
- R10: The fault flag rises in the cycle after a refused write and stays set until reset.
- R11: Byte address bits 31:23 and 1:0 have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register offset for writes and reads |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| blockMode | input | 1 | 1: segments block writes; 0: segments are the only writable regions |
| accValid | input | 1 | Write access strobe |
| accAddr | input | 32 | Byte address of the write |
| accDouble | input | 1 | Double-word write flag |
| accSpace | input | 4 | Address-space code of the write |
| ramWe | output | 1 | RAM write enable for an allowed write |
| faultPulse | output | 1 | One-cycle pulse for a refused write |
| faultFlag | output | 1 | Sticky record of a refused write |
| parityErr | output | 1 | Sticky register-parity error flag |

## Verification
On every cycle the assertions check that ramWe and faultPulse are mutually exclusive and follow the strobe. They also check that the fault flag rises after a fault and never falls, and that an illegal register write raises the parity flag. Only the bench scenarios can show the decision itself. These cover the space-code enables, the inclusive start and exclusive end, the double-word OR at the end boundary, the two modes, the all-disabled case and the register readback layout.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int unsigned SEGS = 2;

  typedef struct packed {
    logic [SEGS-1:0] ldStart;
    logic [SEGS-1:0] ldEnd;
    logic [SEGS-1:0] rdStart;
    logic [SEGS-1:0] rdEnd;
  } wpgStrobe_t;
endpackage

// File: rtl/wpg_ctrl.sv
module wpg_ctrl #(
  parameter int unsigned NSEG     = wpg_pkg::SEGS,
  parameter int unsigned REG_AW   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 23,
  parameter int unsigned CTL_W    = 2,
  parameter logic [7:0]  BASE_OFF = 8'h20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                blockMode,
  input  logic                accValid,
  input  logic [NSEG-1:0]     segHit,
  input  logic [NSEG-1:0]     segArmed,
  output wpg_pkg::wpgStrobe_t strobe,
  output logic                ramWe,
  output logic                faultPulse,
  output logic                faultFlag,
  output logic                parityErr
);
  localparam int unsigned START_HI = ADDR_W + CTL_W;

  logic startBad;
  logic endBad;
  logic anyArmed;
  logic refuse;
  logic parityHit;

  // Register offset decode, one start/end pair per segment, 8 bytes apart
  for (genvar i = 0; i < NSEG; i++) begin : g_dec
    localparam logic [REG_AW-1:0] OFF_S = REG_AW'(BASE_OFF) + REG_AW'(8 * i);
    localparam logic [REG_AW-1:0] OFF_E = OFF_S + REG_AW'(4);
    assign strobe.rdStart[i] = (regAddr == OFF_S);
    assign strobe.rdEnd[i]   = (regAddr == OFF_E);
    assign strobe.ldStart[i] = regWrEn && (regAddr == OFF_S);
    assign strobe.ldEnd[i]   = regWrEn && (regAddr == OFF_E);
  end

  // Reserved-bit detection (R3)
  assign startBad  = |regWrData[DATA_W-1:START_HI];
  assign endBad    = |regWrData[DATA_W-1:ADDR_W];
  assign parityHit = ((|strobe.ldStart) && startBad) || ((|strobe.ldEnd) && endBad);

  // Decision (R6, R7, R8)
  assign anyArmed = |segArmed;
  always_comb begin
    if (!anyArmed)      refuse = 1'b0;
    else if (blockMode) refuse = |segHit;
    else                refuse = ~|(segHit & segArmed);
  end

  assign faultPulse = accValid && refuse;
  assign ramWe      = accValid && !refuse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultFlag <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      if (faultPulse) faultFlag <= 1'b1;
      if (parityHit)  parityErr <= 1'b1;
    end
  end
endmodule

// File: rtl/wpg_datapath.sv
module wpg_datapath #(
  parameter int unsigned NSEG       = wpg_pkg::SEGS,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ACC_W      = 32,
  parameter int unsigned ADDR_W     = 23,
  parameter int unsigned CTL_W      = 2,
  parameter int unsigned SPACE_W    = 4,
  parameter logic [3:0]  USER_SPACE = 4'hA,
  parameter logic [3:0]  SUP_SPACE  = 4'hB
) (
  input  logic                clk,
  input  logic                rstN,
  input  wpg_pkg::wpgStrobe_t strobe,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [ACC_W-1:0]    accAddr,
  input  logic                accDouble,
  input  logic [SPACE_W-1:0]  accSpace,
  output logic [NSEG-1:0]     segHit,
  output logic [NSEG-1:0]     segArmed,
  output logic [DATA_W-1:0]   regRdData
);
  localparam int unsigned PAD_S = DATA_W - ADDR_W - CTL_W;
  localparam int unsigned PAD_E = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] wordAddr;
  logic [ADDR_W-1:0] wordTop;
  logic              isUser;
  logic              isSup;

  // Word address from byte bits ADDR_W-1:2 (R5, R11)
  assign wordAddr = ADDR_W'(accAddr[ADDR_W-1:2]);
  assign wordTop  = wordAddr | ADDR_W'(accDouble);
  assign isUser   = (accSpace == SPACE_W'(USER_SPACE));
  assign isSup    = (accSpace == SPACE_W'(SUP_SPACE));

  logic [DATA_W-1:0] rdPart [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic [ADDR_W-1:0] startQ;
    logic [ADDR_W-1:0] endQ;
    logic [CTL_W-1:0]  ctlQ;
    logic              spaceOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        startQ <= '0;
        endQ   <= '0;
        ctlQ   <= '0;
      end else begin
        if (strobe.ldStart[i]) begin
          startQ <= regWrData[ADDR_W-1:0];
          ctlQ   <= regWrData[ADDR_W +: CTL_W];
        end
        if (strobe.ldEnd[i]) endQ <= regWrData[ADDR_W-1:0];
      end
    end

    assign spaceOk     = (isUser && ctlQ[0]) || (isSup && ctlQ[1]);
    assign segHit[i]   = spaceOk && (wordAddr >= startQ) && (wordTop < endQ);
    assign segArmed[i] = |ctlQ;

    always_comb begin
      rdPart[i] = '0;
      if (strobe.rdStart[i]) rdPart[i] = {{PAD_S{1'b0}}, ctlQ, startQ};
      if (strobe.rdEnd[i])   rdPart[i] = {{PAD_E{1'b0}}, endQ};
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NSEG; i++) regRdData = regRdData | rdPart[i];
  end
endmodule

// File: rtl/ram_write_guard.sv
module ram_write_guard #(
  parameter int unsigned NSEG    = wpg_pkg::SEGS,
  parameter int unsigned REG_AW  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned ADDR_W  = 23,
  parameter int unsigned CTL_W   = 2,
  parameter int unsigned SPACE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               blockMode,
  input  logic               accValid,
  input  logic [ACC_W-1:0]   accAddr,
  input  logic               accDouble,
  input  logic [SPACE_W-1:0] accSpace,
  output logic               ramWe,
  output logic               faultPulse,
  output logic               faultFlag,
  output logic               parityErr
);
  wpg_pkg::wpgStrobe_t strobe;
  logic [NSEG-1:0]     segHit;
  logic [NSEG-1:0]     segArmed;

  wpg_ctrl #(
    .NSEG(NSEG), .REG_AW(REG_AW), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTL_W(CTL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .blockMode(blockMode), .accValid(accValid),
    .segHit(segHit), .segArmed(segArmed), .strobe(strobe), .ramWe(ramWe),
    .faultPulse(faultPulse), .faultFlag(faultFlag), .parityErr(parityErr)
  );

  wpg_datapath #(
    .NSEG(NSEG), .DATA_W(DATA_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W),
    .CTL_W(CTL_W), .SPACE_W(SPACE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .accAddr(accAddr), .accDouble(accDouble), .accSpace(accSpace),
    .segHit(segHit), .segArmed(segArmed), .regRdData(regRdData)
  );
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [7:0]  regAddr,
  input logic [31:0] regWrData,
  input logic        accValid,
  input logic        ramWe,
  input logic        faultPulse,
  input logic        faultFlag,
  input logic        parityErr
);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> $countones({ramWe, faultPulse}) == 1);

  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !ramWe && !faultPulse);

  a_r10_flag_rise: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |=> faultFlag);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |=> faultFlag);

  a_r3_parity_start: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == 8'h20 || regAddr == 8'h28) && (|regWrData[31:25]))
      |=> parityErr);

  a_r3_parity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> parityErr);
endmodule

bind ram_write_guard wpg_checker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .accValid(accValid), .ramWe(ramWe),
  .faultPulse(faultPulse), .faultFlag(faultFlag), .parityErr(parityErr)
);

// File: tb/sim_ram_write_guard.sv
module sim_ram_write_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        blockMode = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accDouble = 1'b0;
  logic [3:0]  accSpace = '0;
  logic        ramWe, faultPulse, faultFlag, parityErr;

  int checks = 0;
  int fails  = 0;

  // Bench model of programmed state
  logic [22:0] mStart [2];
  logic [22:0] mEnd   [2];
  logic [1:0]  mCtl   [2];

  logic  expQ [$];
  string tagQ [$];

  always #2.5 clk = ~clk;

  ram_write_guard u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .blockMode(blockMode),
    .accValid(accValid), .accAddr(accAddr), .accDouble(accDouble),
    .accSpace(accSpace), .ramWe(ramWe), .faultPulse(faultPulse),
    .faultFlag(faultFlag), .parityErr(parityErr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic expRefuse(logic [31:0] a, logic dbl, logic [3:0] sp);
    logic [22:0] w;
    logic [1:0]  hit;
    w = {2'b00, a[22:2]};
    for (int i = 0; i < 2; i++)
      hit[i] = ((sp == 4'hA && mCtl[i][0]) || (sp == 4'hB && mCtl[i][1])) &&
               (w >= mStart[i]) && ((w | {22'b0, dbl}) < mEnd[i]);
    if (mCtl[0] == 2'b00 && mCtl[1] == 2'b00) return 1'b0;
    if (blockMode) return |hit;
    return !((mCtl[0] != 0 && hit[0]) || (mCtl[1] != 0 && hit[1]));
  endfunction

  // Monitor: pops one expectation per strobed cycle
  always @(negedge clk) begin
    if (accValid) begin
      logic  e;
      string t;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9: unexpected strobe, actual 1 expected 0");
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {30'b0, ramWe, faultPulse}, {30'b0, !e, e});
      end
    end
  end

  task automatic regWrite(logic [7:0] off, logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = off; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (off == 8'(8'h20 + 8 * i)) begin
        mStart[i] = d[22:0];
        mCtl[i]   = d[24:23];
      end
      if (off == 8'(8'h24 + 8 * i)) mEnd[i] = d[22:0];
    end
  endtask

  task automatic regRead(string tag, logic [7:0] off, logic [31:0] exp);
    @(negedge clk);
    regAddr = off;
    #0.5;
    chk(tag, regRdData, exp);
  endtask

  task automatic access(string tag, logic [31:0] a, logic dbl, logic [3:0] sp);
    @(posedge clk); #1;
    accValid = 1'b1; accAddr = a; accDouble = dbl; accSpace = sp;
    expQ.push_back(expRefuse(a, dbl, sp));
    tagQ.push_back(tag);
    @(posedge clk); #1;
    accValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      mStart[i] = '0; mEnd[i] = '0; mCtl[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 faultFlag", {31'b0, faultFlag}, 32'h0);
    chk("R1 parityErr", {31'b0, parityErr}, 32'h0);
    regRead("R1 start0", 8'h20, 32'h0);
    regRead("R1 end1", 8'h2C, 32'h0);
    // R8: nothing armed, permit mode still allows
    access("R8 unarmed permit", 32'h0000_0400, 1'b0, 4'hA);
    access("R8 unarmed odd space", 32'h0000_0400, 1'b0, 4'h3);
    // R9: idle cycle
    @(negedge clk);
    chk("R9 idle outputs", {30'b0, ramWe, faultPulse}, 32'h0);

    // R2: program segment 0 for user writes, words 0x100..0x1FE
    regWrite(8'h20, (32'd1 << 23) | 32'h100);
    regWrite(8'h24, 32'h1FF);
    regRead("R2 start0 readback", 8'h20, 32'h0080_0100);
    regRead("R2 end0 readback", 8'h24, 32'h0000_01FF);
    regRead("R2 unmapped offset", 8'h30, 32'h0);
    chk("R3 no parity on legal writes", {31'b0, parityErr}, 32'h0);

    // R6 / R4 / R5 in block mode
    blockMode = 1'b1;
    access("R6 R4 user hit at start", 32'h0000_0400, 1'b0, 4'hA);
    @(negedge clk);
    chk("R10 flag after fault", {31'b0, faultFlag}, 32'h1);
    access("R4 supervisor not enabled", 32'h0000_0400, 1'b0, 4'hB);
    access("R5 below start", 32'h0000_03FC, 1'b0, 4'hA);
    access("R5 last word single", 32'h0000_07F8, 1'b0, 4'hA);
    access("R5 double at last word", 32'h0000_07F8, 1'b1, 4'hA);
    access("R5 end exclusive", 32'h0000_07FC, 1'b0, 4'hA);
    access("R11 upper bits ignored", 32'hFF80_0401, 1'b0, 4'hA);

    // R7 permit mode
    blockMode = 1'b0;
    access("R7 inside allowed", 32'h0000_0500, 1'b0, 4'hA);
    access("R7 outside refused", 32'h0000_0C00, 1'b0, 4'hA);
    access("R7 R4 wrong space refused", 32'h0000_0500, 1'b0, 4'hB);
    access("R7 R4 other space refused", 32'h0000_0500, 1'b0, 4'h9);

    // Segment 1 for supervisor writes
    regWrite(8'h28, (32'd2 << 23) | 32'h300);
    regWrite(8'h2C, 32'h400);
    access("R7 seg1 supervisor allowed", 32'h0000_0C00, 1'b0, 4'hB);
    access("R7 seg1 user refused", 32'h0000_0C00, 1'b0, 4'hA);
    blockMode = 1'b1;
    access("R6 seg1 supervisor blocked", 32'h0000_0FFC, 1'b0, 4'hB);
    @(negedge clk);
    chk("R10 flag sticky", {31'b0, faultFlag}, 32'h1);

    // R3: reserved bits in a start write
    regWrite(8'h28, 32'h4000_0000 | (32'd3 << 23) | 32'h350);
    @(negedge clk);
    chk("R3 parity set by start write", {31'b0, parityErr}, 32'h1);
    regRead("R3 legal start fields kept", 8'h28, 32'h0180_0350);
    regWrite(8'h2C, 32'h0080_0390);
    regRead("R3 legal end fields kept", 8'h2C, 32'h0000_0390);
    access("R3 R6 new range both spaces", 32'h0000_0D40, 1'b0, 4'hA);

    // R8: disarm both segments
    regWrite(8'h20, 32'h100);
    regWrite(8'h28, 32'h350);
    blockMode = 1'b0;
    access("R8 disarmed permit outside", 32'h0000_1C00, 1'b0, 4'hA);
    blockMode = 1'b1;
    access("R8 disarmed block inside", 32'h0000_0400, 1'b0, 4'hA);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 queue drained", 32'(expQ.size()), 32'h0);
    finishRun();
  end
endmodule